// File: doc/BRIEF.md
# DRAM Access and Refresh Sequencer

This block connects a simple synchronous requester to an asynchronous DRAM array. A request carries a read/write flag, a flat word address and, for writes, a data word. The block splits the address into a row part and a column part and puts them one after the other on a shared address bus. It drives the active-low row and column strobes, the write-enable and output-enable lines, and enables its data driver only when a write needs it.

An internal timer raises a refresh request at a fixed period. A refresh counter chooses the row, and each refresh opens that row with the row strobe only. Refresh takes priority over user requests. While an access or a refresh is in progress, a ready/valid handshake holds the requester off. Two status outputs tell the requester whether the block is busy and whether it is refreshing.

Top module: `dram_ctrl`

## Requirements
- R1: While reset is held, and on release, `ras_n`, `cas_n`, `we_n` and `oe_n` are high, `dq_drive`, `busy` and `rd_valid` are low. `req_ready` is high once reset is released.
- R2: `cas_n` is low only while `ras_n` is low. The row strobe falls at least one cycle before the column strobe.
- R3: The row is `req_addr[ROW_W+COL_W-1:COL_W]` and the column is `req_addr[COL_W-1:0]`. The row sits on `dram_addr` when `ras_n` falls and stays there through that edge. The column sits on `dram_addr` while `cas_n` is low.
- R4: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` stays low while `busy` is high.
- R5: For a read, `rd_valid` pulses for one cycle exactly T_ROW+T_RCD+T_CAS cycles after the accepting edge (5 with the defaults). At that point `rd_data` holds the word most recently written to that address.
- R6: `oe_n` goes low only after `cas_n` has been low for at least one full cycle. `oe_n` is never low while `dq_drive` is high.
- R7: During a write, `we_n` is low and `dq_drive` is high before `cas_n` falls. `we_n` and `dq_out` stay unchanged from that point until after `cas_n` rises again.
- R8: The refresh timer raises a refresh request every REF_INT cycles. A pending refresh runs before any waiting request, so requests are held off until the refresh completes and continuous traffic cannot starve refresh.
- R9: A refresh drives the refresh-counter row on `dram_addr` and lowers `ras_n`. It never lowers `cas_n` and never drives the data bus, and `refreshing` is high throughout. The counter starts at row 0 after reset and goes up by one, wrapping, after each refresh.
- R10: Data survives long idle periods because every row is reopened within ROWS*REF_INT cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Flat word address |
| req_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | One-cycle pulse marking valid read data |
| rd_data | output | DATA_W | Read data |
| busy | output | 1 | An access or refresh is in progress |
| refreshing | output | 1 | A refresh is in progress |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| oe_n | output | 1 | Output enable, active low |
| dq_out | output | DATA_W | Data driven toward the array |
| dq_drive | output | 1 | Data driver enable |
| dq_in | input | DATA_W | Data from the array (high-impedance unless the array outputs) |

## Verification
The bench targets three situations. First, a request that arrives while a refresh is running: a design that let it through would lower the column strobe inside the refresh or interleave rows. Second, an unbroken stream of requests: a design that gave requests priority would starve refresh, and the array model would then return corrupted words. Third, a long idle gap followed by readback of every written word: a refresh counter that skipped rows or did not wrap would let some row decay. Alongside these, the array model flags a column strobe outside an open row, output enable too early or while the controller drives the bus, write data moving during the column strobe, and a refresh row out of sequence. A wrong address split shows up as the wrong word read back or as a mismatch in the latched row and column.

// File: rtl/dram_ctrl.sv
module dram_ctrl #(
  parameter int ROW_W   = 3,
  parameter int COL_W   = 3,
  parameter int DATA_W  = 8,
  parameter int T_ROW   = 1,
  parameter int T_RCD   = 2,
  parameter int T_CAS   = 2,
  parameter int T_PRE   = 1,
  parameter int REF_INT = 40
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        req_valid,
  output logic                                        req_ready,
  input  logic                                        req_write,
  input  logic [ROW_W+COL_W-1:0]                      req_addr,
  input  logic [DATA_W-1:0]                           req_wdata,
  output logic                                        rd_valid,
  output logic [DATA_W-1:0]                           rd_data,
  output logic                                        busy,
  output logic                                        refreshing,
  output logic [(ROW_W > COL_W ? ROW_W : COL_W)-1:0]  dram_addr,
  output logic                                        ras_n,
  output logic                                        cas_n,
  output logic                                        we_n,
  output logic                                        oe_n,
  output logic [DATA_W-1:0]                           dq_out,
  output logic                                        dq_drive,
  input  logic [DATA_W-1:0]                           dq_in
);
  localparam int AW = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int TW = (REF_INT > 1) ? $clog2(REF_INT) : 1;

  typedef enum logic [2:0] {S_IDLE, S_ROW, S_RCD, S_COL, S_PRE, S_FROW, S_FACT} st_t;

  st_t               st;
  logic [7:0]        cnt;
  logic [ROW_W-1:0]  row_q, ref_row;
  logic [COL_W-1:0]  col_q;
  logic              wr_q, ref_pend;
  logic [DATA_W-1:0] wd_q;
  logic [TW-1:0]     ref_tmr;
  logic              wr_win;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      row_q    <= '0;
      col_q    <= '0;
      wr_q     <= 1'b0;
      wd_q     <= '0;
      ref_row  <= '0;
      ref_tmr  <= '0;
      ref_pend <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= 1'b0;
      case (st)
        S_IDLE:
          if (ref_pend) begin
            st       <= S_FROW;
            cnt      <= 8'(T_ROW - 1);
            wr_q     <= 1'b0;
            ref_pend <= 1'b0;
          end else if (req_valid) begin
            st    <= S_ROW;
            cnt   <= 8'(T_ROW - 1);
            row_q <= req_addr[ROW_W+COL_W-1:COL_W];
            col_q <= req_addr[COL_W-1:0];
            wr_q  <= req_write;
            wd_q  <= req_wdata;
          end
        S_ROW:
          if (cnt == 0) begin st <= S_RCD; cnt <= 8'(T_RCD - 1); end
          else cnt <= cnt - 1'b1;
        S_RCD:
          if (cnt == 0) begin st <= S_COL; cnt <= 8'(T_CAS - 1); end
          else cnt <= cnt - 1'b1;
        S_COL:
          if (cnt == 0) begin
            st <= S_PRE;
            cnt <= 8'(T_PRE - 1);
            if (!wr_q) begin
              rd_valid <= 1'b1;
              rd_data  <= dq_in;
            end
          end else cnt <= cnt - 1'b1;
        S_PRE:
          if (cnt == 0) st <= S_IDLE;
          else cnt <= cnt - 1'b1;
        S_FROW:
          if (cnt == 0) begin st <= S_FACT; cnt <= 8'(T_RCD + T_CAS - 1); end
          else cnt <= cnt - 1'b1;
        S_FACT:
          if (cnt == 0) begin
            st      <= S_PRE;
            cnt     <= 8'(T_PRE - 1);
            ref_row <= ref_row + 1'b1;
          end else cnt <= cnt - 1'b1;
        default: st <= S_IDLE;
      endcase
      if (ref_tmr == TW'(REF_INT - 1)) begin
        ref_tmr  <= '0;
        ref_pend <= 1'b1;
      end else begin
        ref_tmr <= ref_tmr + 1'b1;
      end
    end
  end

  assign req_ready  = (st == S_IDLE) && !ref_pend;
  assign busy       = (st != S_IDLE);
  assign refreshing = (st == S_FROW) || (st == S_FACT);
  assign ras_n      = !((st == S_RCD) || (st == S_COL) || (st == S_FACT));
  assign cas_n      = (st != S_COL);
  assign wr_win     = wr_q && ((st == S_RCD) || (st == S_COL) || (st == S_PRE));
  assign we_n       = !wr_win;
  assign dq_drive   = wr_win;
  assign dq_out     = wd_q;
  assign oe_n       = !((st == S_COL) && !wr_q && (cnt < 8'(T_CAS - 1)));
  assign dram_addr  = refreshing    ? AW'(ref_row) :
                      (st == S_COL) ? AW'(col_q)   : AW'(row_q);
endmodule

// File: rtl/dram_ctrl_chk.sv
module dram_ctrl_chk #(
  parameter int DATA_W = 8,
  parameter int AW     = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic              oe_n,
  input logic              dq_drive,
  input logic [DATA_W-1:0] dq_out,
  input logic [AW-1:0]     dram_addr,
  input logic              req_ready,
  input logic              busy,
  input logic              refreshing
);
  a_r2_cas_inside_ras: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !ras_n);
  a_r2_ras_leads_cas: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> $past(!ras_n));
  a_r3_row_held_at_ras: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $stable(dram_addr));
  a_r4_no_ready_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);
  a_r6_oe_after_cas: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> (!cas_n && $past(!cas_n) && !dq_drive));
  a_r7_write_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cas_n) |-> ($stable(we_n) && $stable(dq_out)));
  a_r7_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cas_n) |-> ($stable(we_n) && $stable(dq_out)));
  a_r9_refresh_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    refreshing |-> (cas_n && !dq_drive && we_n));
endmodule

bind dram_ctrl dram_ctrl_chk #(
  .DATA_W(DATA_W),
  .AW((ROW_W > COL_W) ? ROW_W : COL_W)
) u_chk (.*);

// File: tb/tb_dram_ctrl.sv
module tb_dram_ctrl;
  localparam int REF_INT = 40;
  localparam int ROWS    = 8;
  localparam int LIMIT   = ROWS * REF_INT + 40;
  localparam int NV      = 14;
  // {write, row[2:0], col[2:0], data}; for reads data is the expected word
  localparam logic [14:0] VEC [NV] = '{
    {1'b1, 6'o00, 8'hA5}, {1'b1, 6'o07, 8'h3C}, {1'b1, 6'o70, 8'h0F},
    {1'b1, 6'o77, 8'hF0}, {1'b1, 6'o25, 8'h81}, {1'b1, 6'o52, 8'h7E},
    {1'b0, 6'o00, 8'hA5}, {1'b0, 6'o77, 8'hF0}, {1'b0, 6'o07, 8'h3C},
    {1'b0, 6'o70, 8'h0F}, {1'b0, 6'o52, 8'h7E}, {1'b0, 6'o25, 8'h81},
    {1'b1, 6'o25, 8'h11}, {1'b0, 6'o25, 8'h11}
  };

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0;
  logic [5:0] req_addr = '0;
  logic [7:0] req_wdata = '0;
  logic req_ready, rd_valid, busy, refreshing;
  logic [7:0] rd_data, dq_out, dq_in;
  logic [2:0] dram_addr;
  logic ras_n, cas_n, we_n, oe_n, dq_drive;

  always #5 clk = ~clk;

  dram_ctrl #(.REF_INT(REF_INT)) dut (.*);

  int total = 0, bad = 0, cyc = 0;
  logic [7:0] shadow [64];

  // behavioural array model
  logic [7:0] mem [64];
  int age [ROWS];
  bit rot [ROWS];
  logic [2:0] row_l = '0, last_row = '0, last_col = '0;
  logic ras_d = 1, cas_d = 1, we_hold = 1;
  logic [7:0] wd_hold = '0;
  int exp_ref = 0, ref_ops = 0, v_r2 = 0, v_r6 = 0, v_r7 = 0, v_r9 = 0;

  assign dq_in = (!oe_n && !cas_n) ?
                 (rot[row_l] ? ~mem[{row_l, dram_addr}] : mem[{row_l, dram_addr}]) : 'z;

  always @(posedge clk) begin
    if (!rst_n) begin
      ras_d <= 1; cas_d <= 1;
      for (int r = 0; r < ROWS; r++) age[r] <= 0;
    end else begin
      ras_d <= ras_n;
      cas_d <= cas_n;
      for (int r = 0; r < ROWS; r++) begin
        age[r] <= age[r] + 1;
        if (age[r] > LIMIT) rot[r] <= 1;
      end
      if (!ras_n && ras_d) begin
        row_l <= dram_addr;
        age[dram_addr] <= 0;
        if (refreshing) begin
          if (int'(dram_addr) != exp_ref) v_r9 <= v_r9 + 1;
          exp_ref <= (exp_ref + 1) % ROWS;
          ref_ops <= ref_ops + 1;
        end else last_row <= dram_addr;
      end
      if (!cas_n && ras_n) v_r2 <= v_r2 + 1;
      if (!cas_n && cas_d) begin
        last_col <= dram_addr;
        we_hold  <= we_n;
        wd_hold  <= dq_out;
        if (!we_n) begin
          mem[{row_l, dram_addr}] <= dq_out;
          if (!dq_drive) v_r7 <= v_r7 + 1;
        end
      end
      if (!cas_n && !cas_d && (we_n != we_hold || (!we_n && dq_out != wd_hold))) v_r7 <= v_r7 + 1;
      if (cas_n && !cas_d && (we_n != we_hold || (!we_n && dq_out != wd_hold))) v_r7 <= v_r7 + 1;
      if (!oe_n && (cas_n || dq_drive)) v_r6 <= v_r6 + 1;
      if (refreshing && (!cas_n || dq_drive)) v_r9 <= v_r9 + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic acc(input bit wr, input logic [5:0] a, input logic [7:0] d,
                     output logic [7:0] q, output int lat);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    chk(!req_ready && busy, "R4 ready low while busy", req_ready, 0);
    lat = 0;
    q = '0;
    if (!wr) begin
      while (!rd_valid) begin @(negedge clk); lat++; end
      q = rd_data;
    end
    while (busy) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 200000) begin
      bad++; total++;
      $display("FAIL watchdog R1..: actual=%0d expected=%0d", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] q;
    int lat, base, t0;
    repeat (3) @(negedge clk);
    chk(ras_n && cas_n && we_n && oe_n && !dq_drive && !busy && !rd_valid,
        "R1 idle lines in reset", {ras_n, cas_n, we_n, oe_n, dq_drive, busy}, 6'b111100);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready, "R1 ready after reset", req_ready, 1);

    for (int i = 0; i < NV; i++) begin
      acc(VEC[i][14], VEC[i][13:8], VEC[i][7:0], q, lat);
      chk(last_row == VEC[i][13:11] && last_col == VEC[i][10:8], "R3 row/col split",
          {last_row, last_col}, VEC[i][13:8]);
      if (VEC[i][14]) shadow[VEC[i][13:8]] = VEC[i][7:0];
      else begin
        chk(q == VEC[i][7:0], "R5 read data", q, VEC[i][7:0]);
        chk(lat == 5, "R5 read latency", lat, 5);
      end
    end

    // R8: request raised during a refresh waits until it finishes
    while (!refreshing) @(negedge clk);
    base = ref_ops;
    acc(1'b0, 6'o00, 8'h00, q, lat);
    chk(ref_ops == base + 1, "R8 request held off by refresh", ref_ops, base + 1);
    chk(q == shadow[0], "R8 data after hold-off", q, shadow[0]);

    // R8: back-to-back traffic does not starve refresh
    base = ref_ops; t0 = cyc;
    for (int i = 0; i < 60; i++) acc(1'b0, 6'(i % 64), 8'h00, q, lat);
    chk(ref_ops - base >= (cyc - t0) / REF_INT - 1, "R8 refresh under load",
        ref_ops - base, (cyc - t0) / REF_INT - 1);

    // R10: long idle, then every written word reads back intact
    repeat (1500) @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][14]) begin
        acc(1'b0, VEC[i][13:8], 8'h00, q, lat);
        chk(q == shadow[VEC[i][13:8]], "R10 retention", q, shadow[VEC[i][13:8]]);
      end
    end
    chk(ref_ops >= 40, "R9 refresh count", ref_ops, 40);

    chk(v_r2 == 0, "R2 column strobe inside open row", v_r2, 0);
    chk(v_r6 == 0, "R6 output enable timing", v_r6, 0);
    chk(v_r7 == 0, "R7 write data/level stable", v_r7, 0);
    chk(v_r9 == 0, "R9 refresh row order and quiet bus", v_r9, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule